// File: doc/BRIEF.md
# Floating-Point Flag Check Branch Unit

This block resolves a floating-point check-flags instruction once decode has supplied its operands. It picks one of four status-field flag vectors, then compares that vector against the trap-control vector and against the primary field (field 0). If any selected flag is not covered by both of them, the check fails.

A failed check either redirects the instruction pointer to a bundle-relative target or, when the core is configured without the branch path, raises a speculative-operation fault. The fault carries the raw immediate, zero-extended, for the interruption-immediate register. A taken redirect can also raise a taken-branch trap, and an unimplemented-instruction-address trap under the address rule that is active. The instruction operands are captured on a valid strobe, and every result is a one-cycle pulse in the next cycle.

Top module: `fcf_unit`

## Requirements
- R1: When the captured qualifying predicate is 0, no redirect, fault or trap output is asserted.
- R2: `sel_i` selects the working flags as `flags_i[6*sel_i+5 : 6*sel_i]`. Field 0 sits at bits 5:0.
- R3: The check fails exactly when some working-flag bit is set while either the same trap-control bit or the same field-0 bit is clear.
- R4: On a failed check with `br_impl_i`=1, `redirect_o` is asserted and `target_o` = `ip_i` + (signed 21-bit `imm_i` × 16), modulo 2^64. When `redirect_o` is low, `target_o` is 0.
- R5: On a failed check with `br_impl_i`=0, `spec_fault_o` is asserted, `redirect_o` stays low, and `iim_o` carries `imm_i` zero-extended to 64 bits. When there is no fault, `iim_o` is 0.
- R6: `taken_trap_o` is asserted exactly when `redirect_o` is asserted and `tb_en_i` was 1.
- R7: `unimpl_trap_o` is asserted exactly when all three of these hold: `redirect_o` is asserted, `uia_sup_i` was 0, and the target is unimplemented. With `it_i`=1 the target is unimplemented when bits 63..VA_BITS-1 are not all equal. With `it_i`=0 it is unimplemented when any bit at or above PA_BITS is set.
- R8: Results appear in the cycle after `valid_i` and last one cycle. `redirect_o` and `spec_fault_o` are never asserted together.
- R9: During and right after reset, all outputs are 0.
- R10: Sign-extending `iim_o[20:0]`, shifting it left by 4 and adding it to the faulting `ip_i` gives the same address as the redirect path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction valid strobe; captures all operands |
| qp_i | input | 1 | Qualifying predicate |
| sel_i | input | 2 | Status-field selector |
| flags_i | input | 24 | Four packed 6-bit field flag vectors |
| trap_ctl_i | input | 6 | Trap-control vector |
| ip_i | input | 64 | Current bundle address (16-byte aligned) |
| imm_i | input | 21 | Signed bundle displacement |
| br_impl_i | input | 1 | Branch path implemented |
| tb_en_i | input | 1 | Taken-branch trap enable |
| it_i | input | 1 | Instruction translation on |
| uia_sup_i | input | 1 | Unimplemented-address faults supported |
| redirect_o | output | 1 | Branch taken |
| target_o | output | 64 | Redirect target |
| spec_fault_o | output | 1 | Speculative-operation fault |
| iim_o | output | 64 | Zero-extended immediate for the fault |
| taken_trap_o | output | 1 | Taken-branch trap |
| unimpl_trap_o | output | 1 | Unimplemented-instruction-address trap |

## Verification
Random flag, trap-control and selector patterns are swept over every combination of the configuration inputs. This separates a failure caused by the trap term from one caused by the field-0 term, and separates selector 0, where the field-0 term cannot fire, from the other selectors. Directed immediates at zero, the largest forward and backward displacements and all-ones test the sign extension. These are paired with bundle addresses placed just below the physical and virtual implemented limits, so that the two address rules and the support mask give different answers. A further round holds the predicate at 0 with failing flags, and a quiet cycle follows every vector to confirm the single-cycle pulse.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
  localparam int FLAG_W   = 6;
  localparam int NUM_FLD  = 4;
  localparam int SEL_W    = $clog2(NUM_FLD);
  localparam int ADDR_W   = 64;
  localparam int IMM_W    = 21;
  localparam int BUNDLE_SH = 4;
  localparam int DISP_W   = IMM_W + BUNDLE_SH;

  typedef struct packed {
    logic                      qp;
    logic [SEL_W-1:0]          sel;
    logic [NUM_FLD*FLAG_W-1:0] flags;
    logic [FLAG_W-1:0]         trap_ctl;
    logic [ADDR_W-1:0]         ip;
    logic [IMM_W-1:0]          imm;
    logic                      br_impl;
    logic                      tb_en;
    logic                      it;
    logic                      uia_sup;
  } instr_t;
endpackage

// File: rtl/fcf_cond.sv
module fcf_cond
  import fcf_pkg::*;
(
  input  logic [NUM_FLD*FLAG_W-1:0] flags_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [FLAG_W-1:0]         trap_ctl_i,
  output logic                      fail_o
);
  logic [FLAG_W-1:0] fld [NUM_FLD];
  logic [FLAG_W-1:0] work;

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
    assign fld[g] = flags_i[g*FLAG_W +: FLAG_W];
  end

  always_comb begin
    work = '0;
    for (int k = 0; k < NUM_FLD; k++) begin
      if (sel_i == SEL_W'(k)) work = fld[k];
    end
  end

  // fails on a flag not disabled by trap control or not already in field 0
  assign fail_o = |(work & ~trap_ctl_i) | |(work & ~fld[0]);
endmodule

// File: rtl/fcf_target.sv
module fcf_target
  import fcf_pkg::*;
(
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] target_o
);
  logic [DISP_W-1:0] disp;
  logic [ADDR_W-1:0] disp_sx;

  assign disp     = {imm_i, {BUNDLE_SH{1'b0}}};
  assign disp_sx  = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign target_o = ip_i + disp_sx;
endmodule

// File: rtl/fcf_addr_chk.sv
module fcf_addr_chk #(
  parameter int HI_W     = 14,
  parameter bit SIGN_EXT = 1'b1
) (
  input  logic [HI_W-1:0] hi_i,
  output logic            unimpl_o
);
  if (SIGN_EXT) begin : g_virt
    // upper bits must all copy the top implemented bit
    assign unimpl_o = !((&hi_i) || (~|hi_i));
  end else begin : g_phys
    assign unimpl_o = |hi_i;
  end
endmodule

// File: rtl/fcf_unit.sv
module fcf_unit
  import fcf_pkg::*;
#(
  parameter int VA_BITS = 51,
  parameter int PA_BITS = 48
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      qp_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [NUM_FLD*FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0]         trap_ctl_i,
  input  logic [ADDR_W-1:0]         ip_i,
  input  logic [IMM_W-1:0]          imm_i,
  input  logic                      br_impl_i,
  input  logic                      tb_en_i,
  input  logic                      it_i,
  input  logic                      uia_sup_i,
  output logic                      redirect_o,
  output logic [ADDR_W-1:0]         target_o,
  output logic                      spec_fault_o,
  output logic [ADDR_W-1:0]         iim_o,
  output logic                      taken_trap_o,
  output logic                      unimpl_trap_o
);
  localparam int VA_HI_W = ADDR_W - VA_BITS + 1;
  localparam int PA_HI_W = ADDR_W - PA_BITS;

  logic              valid_q;
  instr_t            ins_q;
  logic              fail, fire;
  logic [ADDR_W-1:0] tgt;
  logic              va_bad, pa_bad, addr_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ins_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        ins_q.qp       <= qp_i;
        ins_q.sel      <= sel_i;
        ins_q.flags    <= flags_i;
        ins_q.trap_ctl <= trap_ctl_i;
        ins_q.ip       <= ip_i;
        ins_q.imm      <= imm_i;
        ins_q.br_impl  <= br_impl_i;
        ins_q.tb_en    <= tb_en_i;
        ins_q.it       <= it_i;
        ins_q.uia_sup  <= uia_sup_i;
      end
    end
  end

  fcf_cond i_cond (
    .flags_i   (ins_q.flags),
    .sel_i     (ins_q.sel),
    .trap_ctl_i(ins_q.trap_ctl),
    .fail_o    (fail)
  );

  fcf_target i_target (
    .ip_i    (ins_q.ip),
    .imm_i   (ins_q.imm),
    .target_o(tgt)
  );

  fcf_addr_chk #(.HI_W(VA_HI_W), .SIGN_EXT(1'b1)) i_va_chk (
    .hi_i    (tgt[ADDR_W-1:VA_BITS-1]),
    .unimpl_o(va_bad)
  );

  fcf_addr_chk #(.HI_W(PA_HI_W), .SIGN_EXT(1'b0)) i_pa_chk (
    .hi_i    (tgt[ADDR_W-1:PA_BITS]),
    .unimpl_o(pa_bad)
  );

  assign fire     = valid_q & ins_q.qp & fail;
  assign addr_bad = ins_q.it ? va_bad : pa_bad;

  assign redirect_o    = fire & ins_q.br_impl;
  assign spec_fault_o  = fire & ~ins_q.br_impl;
  assign target_o      = redirect_o ? tgt : '0;
  assign iim_o         = spec_fault_o ? {{(ADDR_W-IMM_W){1'b0}}, ins_q.imm} : '0;
  assign taken_trap_o  = redirect_o & ins_q.tb_en;
  assign unimpl_trap_o = redirect_o & ~ins_q.uia_sup & addr_bad;
endmodule

// File: rtl/fcf_unit_chk.sv
module fcf_unit_chk
  import fcf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              qp_i,
  input logic [ADDR_W-1:0] ip_i,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] target_o,
  input logic              spec_fault_o,
  input logic [ADDR_W-1:0] iim_o,
  input logic              taken_trap_o,
  input logic              unimpl_trap_o
);
  a_r1_no_pred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !qp_i) |=> !(redirect_o || spec_fault_o || taken_trap_o || unimpl_trap_o));

  a_r4_bundle_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ip_i[3:0] == 4'h0) |=> (!redirect_o || target_o[3:0] == 4'h0));

  a_r5_iim_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_fault_o |-> (iim_o[ADDR_W-1:IMM_W] == '0));

  a_r6_trap_needs_br: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_trap_o |-> redirect_o);

  a_r7_uia_needs_br: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimpl_trap_o |-> redirect_o);

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(redirect_o && spec_fault_o));

  a_r8_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o || spec_fault_o) |-> $past(valid_i));
endmodule

bind fcf_unit fcf_unit_chk i_fcf_unit_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .qp_i         (qp_i),
  .ip_i         (ip_i),
  .redirect_o   (redirect_o),
  .target_o     (target_o),
  .spec_fault_o (spec_fault_o),
  .iim_o        (iim_o),
  .taken_trap_o (taken_trap_o),
  .unimpl_trap_o(unimpl_trap_o)
);

// File: tb/test_fcf_unit.sv
module test_fcf_unit;
  localparam int VA_B = 51;
  localparam int PA_B = 48;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        qp_i = 1'b0;
  logic [1:0]  sel_i = '0;
  logic [23:0] flags_i = '0;
  logic [5:0]  trap_ctl_i = '0;
  logic [63:0] ip_i = '0;
  logic [20:0] imm_i = '0;
  logic        br_impl_i = 1'b0, tb_en_i = 1'b0, it_i = 1'b0, uia_sup_i = 1'b0;
  logic        redirect_o, spec_fault_o, taken_trap_o, unimpl_trap_o;
  logic [63:0] target_o, iim_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  fcf_unit #(.VA_BITS(VA_B), .PA_BITS(PA_B)) i_fcf_unit (
    .clk_i, .rst_ni, .valid_i, .qp_i, .sel_i, .flags_i, .trap_ctl_i, .ip_i,
    .imm_i, .br_impl_i, .tb_en_i, .it_i, .uia_sup_i, .redirect_o, .target_o,
    .spec_fault_o, .iim_o, .taken_trap_o, .unimpl_trap_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(!redirect_o && !spec_fault_o && !taken_trap_o && !unimpl_trap_o &&
        target_o == 0 && iim_o == 0, req,
        {60'h0, redirect_o, spec_fault_o, taken_trap_o, unimpl_trap_o}, 64'h0);
  endtask

  function automatic logic [63:0] pick_ip(input int k);
    case (k)
      0: return 64'h0000_0000_0000_1000;
      1: return (64'h1 << PA_B) - 64'h100;
      2: return (64'h1 << (VA_B - 1)) - 64'h100;
      3: return 64'hFFFF_FFFF_FFFF_FF00;
      4: return 64'hFFFC_0000_0000_0100;
      default: return {$urandom(), $urandom()} & ~64'hF;
    endcase
  endfunction

  task automatic run_vec(input bit qp, input logic [1:0] sel, input logic [23:0] fl,
                         input logic [5:0] tc, input logic [63:0] ip,
                         input logic [20:0] imm, input bit bi, input bit tb,
                         input bit it, input bit us);
    logic [5:0]  work, f0;
    bit          fail, ex_br, ex_flt, bad;
    logic [63:0] ex_tgt, hnd;
    longint      sx;
    @(negedge clk_i);
    valid_i = 1'b1; qp_i = qp; sel_i = sel; flags_i = fl; trap_ctl_i = tc;
    ip_i = ip; imm_i = imm; br_impl_i = bi; tb_en_i = tb; it_i = it; uia_sup_i = us;
    // R2: field n at bits 6n+5:6n
    work = fl[6*sel +: 6];
    f0   = fl[5:0];
    fail = 1'b0;
    for (int b = 0; b < 6; b++)
      if (work[b] && (!tc[b] || !f0[b])) fail = 1'b1;   // R3
    ex_br  = qp && fail && bi;
    ex_flt = qp && fail && !bi;
    sx     = longint'($signed(imm));
    ex_tgt = ip + 64'(sx * 16);                         // R4
    if (it) begin
      longint s;
      s   = $signed(ex_tgt) >>> (VA_B - 1);
      bad = !(s == 0 || s == -1);
    end else begin
      bad = (ex_tgt >> PA_B) != 0;
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    if (!qp) chk_idle("R1");
    chk(redirect_o == ex_br, "R3 redirect", 64'(redirect_o), 64'(ex_br));
    chk(spec_fault_o == ex_flt, "R5 fault", 64'(spec_fault_o), 64'(ex_flt));
    chk(target_o == (ex_br ? ex_tgt : 64'h0), "R4 target", target_o,
        ex_br ? ex_tgt : 64'h0);
    chk(iim_o == (ex_flt ? {43'h0, imm} : 64'h0), "R5 iim", iim_o,
        ex_flt ? {43'h0, imm} : 64'h0);
    chk(taken_trap_o == (ex_br && tb), "R6 taken trap", 64'(taken_trap_o),
        64'(ex_br && tb));
    chk(unimpl_trap_o == (ex_br && !us && bad), "R7 unimpl trap",
        64'(unimpl_trap_o), 64'(ex_br && !us && bad));
    if (ex_flt) begin
      hnd = ip + {{39{iim_o[20]}}, iim_o[20:0], 4'h0};
      chk(hnd == ex_tgt, "R10 handler target", hnd, ex_tgt);
    end
    @(negedge clk_i);
    chk_idle("R8 single pulse");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R9 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R9 after reset");

    // directed: each selector, trap-only vs field0-only failure
    for (int s = 0; s < 4; s++) begin
      run_vec(1'b1, 2'(s), 24'h1 << (6*s), 6'h3F, 64'h2000, 21'h3, 1'b1, 1'b0, 1'b0, 1'b0);
      run_vec(1'b1, 2'(s), 24'h1 << (6*s), 6'h3E, 64'h2000, 21'h3, 1'b1, 1'b0, 1'b0, 1'b0);
      run_vec(1'b1, 2'(s), 24'h41 << (6*s) | 24'h1, 6'h3F, 64'h2000, 21'h3, 1'b1, 1'b0, 1'b0, 1'b0);
    end
    // directed: immediate extremes across address boundaries, all configs
    for (int k = 0; k < 5; k++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 16; c++) begin
          logic [20:0] im;
          case (m)
            0: im = 21'h000000;
            1: im = 21'h0FFFFF;
            2: im = 21'h100000;
            default: im = 21'h1FFFFF;
          endcase
          run_vec(1'b1, 2'd1, 24'h000040, 6'h00, pick_ip(k), im,
                  c[0], c[1], c[2], c[3]);
        end
    // R1: predicate off with failing flags
    for (int c = 0; c < 16; c++)
      run_vec(1'b0, 2'(c), 24'hFFFFC0, 6'h00, 64'h4000, 21'h10,
              c[0], c[1], c[2], c[3]);
    // random sweep
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r;
      r = $urandom();
      run_vec(r[0] | r[1], r[3:2], 24'($urandom()), 6'($urandom()),
              pick_ip(n % 7), 21'($urandom()), r[4], r[5], r[6], r[7]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule